// File: doc/BRIEF.md
# GPIO Controller with Both-Edge Change Interrupt

This block is a small register-mapped general purpose I/O controller. It sits on a simple word-addressed bus that has separate read and write strobes. Each pin has a direction bit and an output value bit, and drives a pad through separate output-enable and output-value signals. It reads the pad level back through a two-flop synchroniser.

Every transition of a synchronised pin level sets a sticky change bit, whether the pin rises or falls. Software clears a change bit by writing a one to it. A single interrupt line is raised while any change bit is set whose per-pin enable is also set. Writes to the output value register can be limited by a write mask, so that only selected pins are updated. The number of pins is a parameter from 2 to 32, and register bits above that number read as zero.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, direction, interrupt enable and change registers read 0, `pin_oe` is all zero, `irq` is low, and the write mask reads as all ones over the implemented pins.
- R2: Word 0 is the direction register, and bit value 1 means output. `pin_oe` equals the direction register and `pin_out` equals the stored output value, starting the cycle after the write.
- R3: A read of word 1 returns the pad level of each pin after two synchroniser flops. A level applied at `pin_in` is visible to a read issued two clock edges later. Read data appears on `rdata` the cycle after the `rd_en` edge.
- R4: A rising or falling transition on any pin sets that pin's bit in the change register (word 3). The bit is set on the third rising clock edge after the pad changes.
- R5: Writing word 3 clears each change bit where the written data has a 1, and leaves bits written with 0 unchanged.
- R6: If a new transition is detected on a pin in the same cycle that a clear write targets its change bit, the bit stays set.
- R7: `irq` is high exactly while some change bit and the matching enable bit in word 2 are both 1.
- R8: A write to word 1 updates only the output value bits whose write-mask bit (word 4) is 1. The mask is readable and writable.
- R9: Word 5 always reads the constant 3, meaning both edges, and writes to it have no effect.
- R10: Register bits at or above the pin count read 0, and reads of unmapped words (6 and 7) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| pin_in | input | PINS | Pad input levels |
| pin_out | output | PINS | Pad output values |
| pin_oe | output | PINS | Pad output enables |
| irq | output | 1 | Combined change interrupt |

## Verification
A lost or stuck change bit shows at `irq` three edges after a pad transition when its enable is set, and at a read of word 3 one cycle later. A wrong synchroniser or edge stage shifts that point by a cycle, so the bench samples exactly on the third edge and also one edge before it. A corrupted output value or mask shows on `pin_out` the cycle after the write. The coincident clear and edge case is driven on the exact cycle so that a design that lets the clear win reads back zero.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int PINS      = 16,
  parameter int ADDR_W    = 3,
  parameter int TYPE_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CHG  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(5);

  logic [PINS-1:0] dir_q, val_q, ien_q, chg_q, mask_q;
  logic [PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [PINS-1:0] edge_hit, clr_bits, wd;

  assign wd       = wdata[PINS-1:0];
  assign edge_hit = sync2_q ^ prev_q;
  assign clr_bits = (wr_en && addr == A_CHG) ? wd : '0;
  assign pin_oe   = dir_q;
  assign pin_out  = val_q;
  assign irq      = |(chg_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      val_q  <= '0;
      ien_q  <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      case (addr)
        A_DIR:   dir_q  <= wd;
        A_VAL:   val_q  <= (val_q & ~mask_q) | (wd & mask_q);
        A_IEN:   ien_q  <= wd;
        A_MASK:  mask_q <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= (chg_q & ~clr_bits) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_DIR:   rdata <= 32'(dir_q);
        A_VAL:   rdata <= 32'(sync2_q);
        A_IEN:   rdata <= 32'(ien_q);
        A_CHG:   rdata <= 32'(chg_q);
        A_MASK:  rdata <= 32'(mask_q);
        A_TYPE:  rdata <= 32'(TYPE_CODE);
        default: rdata <= '0;
      endcase
    end
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((chg_q & $past(edge_hit)) == $past(edge_hit)));  // R4

  AST_CLEAR_WINS_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CHG && edge_hit == '0) |=> (chg_q == ($past(chg_q) & ~$past(wd))));  // R5

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (pin_oe == $past(wd)));  // R2

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_VAL) |=> (((pin_out ^ $past(pin_out)) & ~$past(mask_q)) == '0));  // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q == '0) |-> !irq);  // R7

  AST_TYPE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_TYPE) |=> (rdata == 32'(TYPE_CODE)));  // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata >> PINS) == 32'd0);  // R10

endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [PINS-1:0] pin_in, pin_out, pin_oe, ext;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_edge_ctrl #(.PINS(PINS), .ADDR_W(3), .TYPE_CODE(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    cyc(1);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic clear_all();
    cyc(3);
    wr(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 oe", 32'(pin_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(3'd0, d); check("R1 dir", d, 32'h0);
    rd(3'd2, d); check("R1 ien", d, 32'h0);
    rd(3'd3, d); check("R1 chg", d, 32'h0);
    rd(3'd4, d); check("R1 mask", d, 32'h0000_FFFF);
  endtask

  task automatic t_dir_data();
    logic [31:0] d;
    wr(3'd0, 32'h0000_00F0);
    wr(3'd1, 32'h0000_00A0);
    check("R2 oe", 32'(pin_oe), 32'h0000_00F0);
    check("R2 out", 32'(pin_out), 32'h0000_00A0);
    ext = 16'h0003;
    cyc(2);
    rd(3'd1, d); check("R3 pad read", d, 32'h0000_00A3);
    clear_all();
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(3'd2, 32'h0);
    ext[2] = 1'b1;
    cyc(3);
    check("R7 masked irq", 32'(irq), 32'h0);
    rd(3'd3, d); check("R4 rise", d, 32'h0000_0004);
    wr(3'd3, 32'h0);
    rd(3'd3, d); check("R5 zero keeps", d, 32'h0000_0004);
    wr(3'd3, 32'h0000_0004);
    rd(3'd3, d); check("R5 one clears", d, 32'h0);
    wr(3'd2, 32'h0000_0004);
    ext[2] = 1'b0;
    cyc(2);
    check("R4 not before third edge", 32'(irq), 32'h0);
    cyc(1);
    check("R4 fall third edge", 32'(irq), 32'h1);
    wr(3'd2, 32'h0000_0008);
    check("R7 other enable", 32'(irq), 32'h0);
    wr(3'd3, 32'h0000_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(3'd2, 32'h0000_0008);
    ext[3] = 1'b1;
    cyc(3);
    check("R7 irq on", 32'(irq), 32'h1);
    ext[3] = 1'b0;
    cyc(2);
    wr(3'd3, 32'h0000_0008);
    rd(3'd3, d); check("R6 edge beats clear", d, 32'h0000_0008);
    wr(3'd3, 32'h0000_0008);
    rd(3'd3, d); check("R5 clear later", d, 32'h0);
    check("R7 irq off", 32'(irq), 32'h0);
  endtask

  task automatic t_wmask();
    logic [31:0] d;
    wr(3'd0, 32'h0000_FF00);
    wr(3'd1, 32'h0000_FFFF);
    wr(3'd4, 32'h0000_0F00);
    wr(3'd1, 32'h0);
    check("R8 masked write", 32'(pin_out), 32'h0000_F0FF);
    rd(3'd4, d); check("R8 mask readback", d, 32'h0000_0F00);
    wr(3'd4, 32'h0000_FFFF);
    clear_all();
  endtask

  task automatic t_type_upper();
    logic [31:0] d;
    rd(3'd5, d); check("R9 type", d, 32'h3);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); check("R9 type after write", d, 32'h3);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R10 upper bits", d, 32'h0000_FFFF);
    rd(3'd6, d); check("R10 unmapped", d, 32'h0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    ext = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_dir_data();
    t_edges();
    t_collide();
    t_wmask();
    t_type_upper();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule